// File: doc/BRIEF.md
# Cascadable dual 8-bit timer

Two 8-bit up-counters share one register port. Each counter has a compare register, a clear selection, and two sticky flags: compare-match and overflow. Each counter normally advances on a prescaled count-enable input. A chaining code in the clock-select field links the two counters.

With the chaining code in channel 0, the pair forms one 16-bit counter. Channel 0 is the upper byte and channel 1 is the lower byte. Channel 0's clear setting then clears both bytes together. With the chaining code only in channel 1, channel 1 counts the compare-match events of channel 0.

Software programs the block through a single-cycle write strobe with an address. Readback is combinational. The live counts and flags are also brought out as ports.

Top module: `tmr_cascade_dual`

## Requirements
- R1: After reset, both counts are 0x00, both compare registers are 0xFF, both control registers are 0 and all four flags are 0.
- R2: The register address map is as follows. Control registers are at 0 and 1, compare registers at 2 and 3, count registers at 4 and 5, and status registers at 6 and 7; channel 0 takes the even address of each pair. A control register holds clock select in bits 2:0 and clear select in bits 4:3, and reads back with bits 7:5 as zero. Status has overflow in bit 0 and compare-match in bit 1. Every register reads back on `rdata_o` in the same cycle the address is presented.
- R3: Outside the chaining modes, clock select 3'b000 stops a counter. Any code other than 3'b000 and 3'b100 advances the counter by one on each clock edge where `tick_i` is high.
- R4: A channel's overflow flag sets on the edge where its count rolls from 0xFF to 0x00 by incrementing.
- R5: A compare-match event is the first cycle in which the count equals the compare value, and it sets the compare-match flag at the next edge. Clear select 2'b01 clears the counter at that edge in place of counting. Clear select 2'b10 on channel 0 clears it at every edge where `ext_clr_i` is high. Other clear-select codes never clear.
- R6: Flags are sticky. Writing 0 to a status bit clears that flag and writing 1 leaves it unchanged. A set event at the same edge wins over the clear.
- R7: Clock select 3'b100 in channel 0 forms a 16-bit counter, with channel 0 as the upper byte. In this mode the lower byte advances with `tick_i` according to channel 1's clock select. The upper byte increments one cycle after the lower byte rolls from 0xFF to 0x00.
- R8: In 16-bit mode, channel 0's compare-match flag sets only on a full 16-bit match against {compare 0, compare 1}. Channel 1's flag sets on a lower-byte match alone.
- R9: In 16-bit mode, channel 0's clear select clears both bytes together. Channel 1's clear select is ignored, and the lower byte is never cleared on its own.
- R10: Clock select 3'b100 in channel 1, while channel 0 is not 3'b100, makes channel 1 increment once per channel 0 compare-match event.
- R11: For each counter, clearing takes priority over a software count write, and a software count write takes priority over incrementing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` |
| tick_i | input | 1 | Prescaled count enable |
| ext_clr_i | input | 1 | External clear for channel 0, active high |
| cnt0_o | output | 8 | Channel 0 count (upper byte in 16-bit mode) |
| cnt1_o | output | 8 | Channel 1 count (lower byte in 16-bit mode) |
| cmf_o | output | 2 | Compare-match flags, bit n for channel n |
| ovf_o | output | 2 | Overflow flags, bit n for channel n |

## Verification
The assertions check the following on every cycle:
- an overflow flag only rises as its count lands on zero, and only falls after a status write of 0;
- the upper byte in 16-bit mode only steps while the lower byte sits at zero;
- a 16-bit match flag only rises after the full 16-bit count equalled both compare registers;
- the lower byte never reaches zero alone by clearing.

Only the bench scenarios can show the remaining behaviour:
- the reset values and the register readback;
- the compare period with clear-on-match;
- the priority of clear over count write;
- a flag set winning over its clear;
- channel 1's ignored clear setting;
- event counting in the chained mode.

// File: rtl/tmr_cascade_pkg.sv
package tmr_cascade_pkg;

  localparam int unsigned CTL_W = 5;

  localparam logic [2:0] CKS_STOP  = 3'b000;
  localparam logic [2:0] CKS_CHAIN = 3'b100;

  localparam logic [1:0] CLR_NONE  = 2'b00;
  localparam logic [1:0] CLR_MATCH = 2'b01;
  localparam logic [1:0] CLR_EXT   = 2'b10;

  // register bases; channel index is added
  localparam int unsigned A_CTL = 0;
  localparam int unsigned A_CMP = 2;
  localparam int unsigned A_CNT = 4;
  localparam int unsigned A_STS = 6;

  typedef struct packed {
    logic [1:0] clr_sel;
    logic [2:0] clk_sel;
  } tmr_ctl_t;

  function automatic logic uses_tick(logic [2:0] sel);
    return (sel != CKS_STOP) && (sel != CKS_CHAIN);
  endfunction

endpackage

// File: rtl/tmr_match_det.sv
module tmr_match_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         hit_o
);
  logic eq, eq_q;

  assign eq    = (a_i == b_i);
  assign hit_o = eq & ~eq_q;  // first cycle of equality only

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b0;
    else         eq_q <= eq;
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  input  logic         cnt_we_i,
  input  logic         cmp_we_i,
  input  logic         sts_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         cmf_set_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cmp_o,
  output logic         cmf_o,
  output logic         ovf_o,
  output logic         roll_o
);
  logic [W-1:0] cnt_q, cmp_q;
  logic         cmf_q, ovf_q;

  assign roll_o = inc_i & ~clr_i & ~cnt_we_i & (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= '1;
      cmf_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (clr_i)         cnt_q <= '0;
      else if (cnt_we_i) cnt_q <= wdata_i;
      else if (inc_i)    cnt_q <= cnt_q + 1'b1;

      if (cmp_we_i) cmp_q <= wdata_i;

      if (cmf_set_i)                  cmf_q <= 1'b1;
      else if (sts_we_i & ~wdata_i[1]) cmf_q <= 1'b0;

      if (roll_o)                     ovf_q <= 1'b1;
      else if (sts_we_i & ~wdata_i[0]) ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;
  assign cmf_o = cmf_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/tmr_cascade_dual.sv
module tmr_cascade_dual
  import tmr_cascade_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  input  logic          tick_i,
  input  logic          ext_clr_i,
  output logic [W-1:0]  cnt0_o,
  output logic [W-1:0]  cnt1_o,
  output logic [1:0]    cmf_o,
  output logic [1:0]    ovf_o
);
  localparam int unsigned NCH = 2;

  tmr_ctl_t [NCH-1:0]        ctl_q;
  logic [NCH-1:0][W-1:0]     cnt_w, cmp_w;
  logic [NCH-1:0]            inc, clr, roll, cmf_set;
  logic [NCH-1:0]            cnt_we, cmp_we, sts_we;
  logic                      mode16, evmode, carry_q;
  logic                      hit0, hit1, hit16, mev0, clr0;

  assign mode16 = (ctl_q[0].clk_sel == CKS_CHAIN);
  assign evmode = ~mode16 & (ctl_q[1].clk_sel == CKS_CHAIN);

  tmr_match_det #(.W(W)) u_hit0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(cnt_w[0]), .b_i(cmp_w[0]), .hit_o(hit0));
  tmr_match_det #(.W(W)) u_hit1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(cnt_w[1]), .b_i(cmp_w[1]), .hit_o(hit1));
  tmr_match_det #(.W(2*W)) u_hit16 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .a_i({cnt_w[0], cnt_w[1]}), .b_i({cmp_w[0], cmp_w[1]}), .hit_o(hit16));

  assign mev0 = mode16 ? hit16 : hit0;

  always_comb begin
    unique case (ctl_q[0].clr_sel)
      CLR_MATCH: clr0 = mev0;
      CLR_EXT:   clr0 = ext_clr_i;
      default:   clr0 = 1'b0;
    endcase
    clr[0] = clr0;
    // in 16-bit mode the lower byte follows channel 0's clear only
    clr[1] = mode16 ? clr0 : ((ctl_q[1].clr_sel == CLR_MATCH) & hit1);

    inc[0] = mode16 ? carry_q : (uses_tick(ctl_q[0].clk_sel) & tick_i);
    if (evmode) inc[1] = mev0;
    else        inc[1] = uses_tick(ctl_q[1].clk_sel) & tick_i;

    cmf_set[0] = mev0;
    cmf_set[1] = hit1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) carry_q <= 1'b0;
    else         carry_q <= mode16 & roll[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (we_i && (int'(addr_i) == A_CTL + c)) ctl_q[c] <= wdata_i[CTL_W-1:0];
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign cnt_we[c] = we_i & (int'(addr_i) == A_CNT + c);
    assign cmp_we[c] = we_i & (int'(addr_i) == A_CMP + c);
    assign sts_we[c] = we_i & (int'(addr_i) == A_STS + c);

    tmr_chan #(.W(W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (inc[c]),
      .clr_i    (clr[c]),
      .cnt_we_i (cnt_we[c]),
      .cmp_we_i (cmp_we[c]),
      .sts_we_i (sts_we[c]),
      .wdata_i  (wdata_i),
      .cmf_set_i(cmf_set[c]),
      .cnt_o    (cnt_w[c]),
      .cmp_o    (cmp_w[c]),
      .cmf_o    (cmf_o[c]),
      .ovf_o    (ovf_o[c]),
      .roll_o   (roll[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (int'(addr_i) == A_CTL + c) rdata_o = W'(ctl_q[c]);
      if (int'(addr_i) == A_CMP + c) rdata_o = cmp_w[c];
      if (int'(addr_i) == A_CNT + c) rdata_o = cnt_w[c];
      if (int'(addr_i) == A_STS + c) rdata_o = W'({cmf_o[c], ovf_o[c]});
    end
  end

  assign cnt0_o = cnt_w[0];
  assign cnt1_o = cnt_w[1];
endmodule

// File: rtl/tmr_cascade_dual_chk.sv
module tmr_cascade_dual_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [W-1:0]  wdata_i,
  input logic [W-1:0]  cnt0_o,
  input logic [W-1:0]  cnt1_o,
  input logic [1:0]    cmf_o,
  input logic [1:0]    ovf_o,
  input logic          mode16,
  input logic [W-1:0]  cmp0,
  input logic [W-1:0]  cmp1
);
  assert_ovf_roll_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o[0]) |-> (cnt0_o == '0));

  assert_ovf1_roll_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o[1]) |-> (cnt1_o == '0));

  assert_flag_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_o[0]) |-> $past(we_i && (int'(addr_i) == 6) && !wdata_i[0]));

  assert_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode16) && !$past(we_i) && (cnt0_o != $past(cnt0_o)) && (cnt0_o != '0))
      |-> ($past(cnt1_o) == '0));

  assert_cmf16_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cmf_o[0]) && $past(mode16))
      |-> ($past({cnt0_o, cnt1_o}) == $past({cmp0, cmp1})));

  assert_no_lone_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode16) && !$past(we_i) && (cnt1_o == '0) &&
     ($past(cnt1_o) != '0) && ($past(cnt1_o) != '1)) |-> (cnt0_o == '0));
endmodule

bind tmr_cascade_dual tmr_cascade_dual_chk #(.W(W), .AW(AW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .cnt0_o (cnt0_o),
  .cnt1_o (cnt1_o),
  .cmf_o  (cmf_o),
  .ovf_o  (ovf_o),
  .mode16 (mode16),
  .cmp0   (cmp_w[0]),
  .cmp1   (cmp_w[1])
);

// File: tb/tmr_cascade_dual_bench.sv
`timescale 1ns/1ps
module tmr_cascade_dual_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       we, tick, xclr;
  logic [2:0] addr;
  logic [7:0] wd, rdata, cnt0, cnt1;
  logic [1:0] cmf, ovf;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req  = "R1";
  bit    done     = 1'b0;

  always #4 clk = ~clk;

  tmr_cascade_dual u_tmr_cascade_dual (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wd),
    .rdata_o(rdata), .tick_i(tick), .ext_clr_i(xclr),
    .cnt0_o(cnt0), .cnt1_o(cnt1), .cmf_o(cmf), .ovf_o(ovf));

  // ---- behavioural reference model ----
  int m_cnt[2], m_cmp[2], m_ctl[2], m_cmf[2], m_ovf[2];
  int m_eq0, m_eq1, m_eq16, m_carry;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_cnt[c] = 0; m_cmp[c] = 255; m_ctl[c] = 0; m_cmf[c] = 0; m_ovf[c] = 0;
    end
    m_eq0 = 0; m_eq1 = 0; m_eq16 = 0; m_carry = 0;
  endtask

  function automatic int m_read(int a);
    case (a)
      0, 1:    return m_ctl[a];
      2, 3:    return m_cmp[a-2];
      4, 5:    return m_cnt[a-4];
      default: return m_cmf[a-6] * 2 + m_ovf[a-6];
    endcase
  endfunction

  function automatic bit ticks(int ctl);
    return ((ctl % 8) != 0) && ((ctl % 8) != 4);
  endfunction

  task automatic model_step();
    int  a, nx[2], clrv[2], incv[2], wc[2], rl[2], setf[2];
    bit  chain16, evc, e0, e1, e16, h0, h1, h16, ev0;
    a = int'(addr);
    chain16 = (m_ctl[0] % 8) == 4;
    evc     = !chain16 && ((m_ctl[1] % 8) == 4);
    e0  = m_cnt[0] == m_cmp[0];
    e1  = m_cnt[1] == m_cmp[1];
    e16 = e0 && e1;
    h0  = e0 && !m_eq0;  h1 = e1 && !m_eq1;  h16 = e16 && !m_eq16;
    ev0 = chain16 ? h16 : h0;
    clrv[0] = ((m_ctl[0] / 8) == 1) ? ev0 : ((m_ctl[0] / 8) == 2) ? int'(xclr) : 0;
    clrv[1] = chain16 ? clrv[0] : (((m_ctl[1] / 8) == 1) && h1);
    incv[0] = chain16 ? m_carry : (ticks(m_ctl[0]) && tick);
    incv[1] = evc ? ev0 : (ticks(m_ctl[1]) && tick);
    setf[0] = ev0; setf[1] = h1;
    for (int c = 0; c < 2; c++) begin
      wc[c] = we && (a == 4 + c);
      rl[c] = incv[c] && !clrv[c] && !wc[c] && (m_cnt[c] == 255);
      if (clrv[c])      nx[c] = 0;
      else if (wc[c])   nx[c] = int'(wd);
      else if (incv[c]) nx[c] = (m_cnt[c] + 1) % 256;
      else              nx[c] = m_cnt[c];
    end
    m_eq0 = e0; m_eq1 = e1; m_eq16 = e16;
    m_carry = chain16 && rl[1];
    for (int c = 0; c < 2; c++) begin
      m_cnt[c] = nx[c];
      if (setf[c]) m_cmf[c] = 1;
      else if (we && a == 6 + c && !wd[1]) m_cmf[c] = 0;
      if (rl[c]) m_ovf[c] = 1;
      else if (we && a == 6 + c && !wd[0]) m_ovf[c] = 0;
      if (we && a == c)     m_ctl[c] = int'(wd) % 32;
      if (we && a == 2 + c) m_cmp[c] = int'(wd);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      longint act, exp;
      model_step();
      #2;
      act = {cnt0, cnt1, cmf, ovf, rdata};
      exp = (longint'(m_cnt[0]) << 20) | (longint'(m_cnt[1]) << 12) |
            (longint'(m_cmf[1]) << 11) | (longint'(m_cmf[0]) << 10) |
            (longint'(m_ovf[1]) << 9) | (longint'(m_ovf[0]) << 8) |
            longint'(m_read(int'(addr)));
      chk(act == exp, cur_req, act, exp);
    end
  end

  // ---- stimulus helpers ----
  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = 3'(a); wd = 8'(d);
    @(posedge clk);
  endtask

  task automatic rel();
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int mx0, mx1, ev, prev1, expect_up;
    bit seen_up;
    we = 0; addr = 0; wd = 0; tick = 0; xclr = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    cur_req = "R1";
    #1 chk(cnt0 == 0 && cnt1 == 0, "R1", {cnt0, cnt1}, 0);
    chk({cmf, ovf} == 0, "R1", {cmf, ovf}, 0);
    addr = 2; #1 chk(rdata == 8'hFF, "R1", rdata, 8'hFF);
    addr = 3; #1 chk(rdata == 8'hFF, "R1", rdata, 8'hFF);

    // R2 control readback masks upper bits
    cur_req = "R2";
    wr(1, 8'hFF); rel();
    addr = 1; #1 chk(rdata == 8'h1F, "R2", rdata, 8'h1F);
    wr(1, 0); wr(3, 8'hA5); rel();
    addr = 3; #1 chk(rdata == 8'hA5, "R2", rdata, 8'hA5);

    // R3 counting on tick, stop code
    cur_req = "R3";
    wr(0, 1); rel();
    tick = 1; cyc(10);
    chk(cnt0 == 10 && cnt1 == 0, "R3", {cnt0, cnt1}, 16'h0A00);
    for (int i = 0; i < 10; i++) begin @(negedge clk); tick = ~tick; end
    tick = 0;
    chk(cnt0 == 15, "R3", cnt0, 15);
    wr(0, 0); rel(); tick = 1; cyc(5);
    chk(cnt0 == 15, "R3", cnt0, 15);

    // R4 overflow
    cur_req = "R4";
    wr(0, 1); wr(4, 8'hFD); rel(); cyc(4);
    chk(ovf[0] == 1'b1, "R4", ovf[0], 1);

    // R6 sticky flags, write-1 keeps, write-0 clears, set wins
    cur_req = "R6";
    wr(6, 8'h01); rel();
    chk(ovf[0] == 1'b1, "R6", ovf[0], 1);
    wr(6, 0); rel();
    chk(ovf[0] == 1'b0, "R6", ovf[0], 0);
    wr(4, 8'hFE); rel(); cyc(3);
    wr(4, 8'hFF); wr(6, 0); rel();
    chk(ovf[0] == 1'b1, "R6", ovf[0], 1);

    // R5 compare match with clear-on-match
    cur_req = "R5";
    tick = 0;
    wr(2, 5); wr(0, 8'h09); wr(4, 0); wr(6, 0); rel();
    tick = 1; mx0 = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); if (int'(cnt0) > mx0) mx0 = int'(cnt0);
    end
    chk(mx0 == 5, "R5", mx0, 5);
    chk(cmf[0] == 1'b1, "R5", cmf[0], 1);
    wr(0, 8'h11); rel(); cyc(3);
    xclr = 1; @(negedge clk); xclr = 0;
    chk(cnt0 == 0, "R5", cnt0, 0);

    // R11 clear beats write, write beats increment
    cur_req = "R11";
    cyc(2);
    xclr = 1; we = 1; addr = 4; wd = 8'h33;
    @(negedge clk); xclr = 0; we = 0;
    chk(cnt0 == 0, "R11", cnt0, 0);
    wr(4, 8'h33); rel();
    chk(cnt0 == 8'h33, "R11", cnt0, 8'h33);

    // R7 R8 R9 16-bit mode, channel 1 clear setting ignored
    cur_req = "R7";
    tick = 0;
    wr(0, 0); wr(1, 0); wr(4, 0); wr(5, 0); wr(6, 0); wr(7, 0);
    wr(2, 1); wr(3, 3); wr(1, 8'h0D); wr(0, 8'h0C); rel();
    tick = 1; mx0 = 0; mx1 = 0; prev1 = 0; expect_up = 0; seen_up = 0;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (expect_up) begin
        chk(cnt0 == 1, "R7", cnt0, 1);
        seen_up = 1; expect_up = 0;
      end
      if (prev1 == 255 && cnt1 == 0 && cnt0 == 0) expect_up = 1;
      if (int'(cnt0) > mx0) mx0 = int'(cnt0);
      if (int'(cnt1) > mx1) mx1 = int'(cnt1);
      prev1 = int'(cnt1);
    end
    chk(seen_up, "R7", seen_up, 1);
    chk(mx0 == 1, "R9", mx0, 1);
    chk(mx1 == 255, "R9", mx1, 255);
    chk(cmf == 2'b11, "R8", cmf, 2'b11);

    // R10 event counting of channel 0 matches
    cur_req = "R10";
    tick = 0;
    wr(0, 0); wr(1, 0); wr(4, 0); wr(5, 0); wr(2, 3); wr(0, 9); wr(1, 4); rel();
    tick = 1; ev = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); if (cnt0 == 3) ev++;
    end
    @(negedge clk);
    chk(int'(cnt1) == ev && ev > 5, "R10", cnt1, ev);

    done = 1;
    summary();
  end
endmodule